// File: doc/BRIEF.md
# Rename Register Credit Tracker

This block keeps count of how many physical rename entries are held in several register pools of an out-of-order core. Pool 0 is a global pool: every charge and every release lands there, whatever the other pool is. Each architectural register carries a class entry that holds a pool index and a cost. The cost is the number of physical entries that one definition of that register takes. A definition is charged to pool 0 and also to its own pool when that pool index is nonzero.

Rename logic uses three paths. The allocate lanes charge destinations as they rename. The free lanes release them at retirement. The combinational query takes a group of candidate destinations and returns one stall bit per pool, set for each pool that could not absorb the group. A small write port loads the class table and the pool capacities. A capacity of zero means the pool has no limit. Choosing actual physical register numbers happens elsewhere.

Allocate and free lanes are single-cycle strobes with no ready signal. Every strobe is accepted in the cycle it is presented, so back-pressure is the caller's job: it must hold a rename group back while any stall bit reported for that group is set. The query carries no state and may be presented every cycle.

Top module: `rename_credit_tracker`

## Requirements
- R1: After reset every used count and both error flags are 0. Every register class maps to pool 0 with cost 1. Pool 0 capacity is POOL0_CAP and every other pool has capacity 0.
- R2: A valid allocate lane whose skip bit is 0 adds its class cost to pool 0 and to the class pool when that index is nonzero. The counts change on the next clock edge. A class in pool 0 is charged once.
- R3: A valid free lane whose skip bit is 0 subtracts the same amounts that an allocate of that register adds, on the next clock edge.
- R4: A lane whose skip bit is 1 changes no count, for both allocate and free.
- R5: Allocates and frees presented in the same cycle are all applied together. Each count becomes used + charged − released.
- R6: For each pool p, the query computes required(p), the summed cost over the valid query lanes. qry_stall[p] is then 1 exactly when required(p) > 0, capacity(p) ≠ 0 and capacity(p) < used(p) + required(p). The result is combinational, in the same cycle.
- R7: A pool with capacity 0 never sets its stall bit.
- R8: A pool that the current query does not touch (required = 0) keeps its stall bit clear, even when it is full.
- R9: If a valid query needs more entries than the nonzero capacity of some pool, err_fatal is set on the next edge and stays set until reset.
- R10: If a release would take a count below zero, that count becomes 0. err_underflow is then set on the next edge and stays set until reset.
- R11: A class write (register, pool, cost) or a capacity write (pool, value) takes effect from the next clock edge. A query in the same cycle still sees the old value.
- R12: Several lanes hitting the same pool in one cycle add up, for allocation and for the query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_map_we | input | 1 | Write strobe for a class entry |
| cfg_map_reg | input | REG_W | Architectural register whose entry is written |
| cfg_map_pool | input | PIDX_W | New pool index |
| cfg_map_cost | input | COST_W | New cost |
| cfg_cap_we | input | 1 | Write strobe for a pool capacity |
| cfg_cap_pool | input | PIDX_W | Pool whose capacity is written |
| cfg_cap_val | input | CNT_W | New capacity, 0 = unbounded |
| alloc_vld | input | NUM_DST | Per-lane allocate strobe |
| alloc_skip | input | NUM_DST | Per-lane: the allocate takes no physical entry |
| alloc_reg | input | NUM_DST*REG_W | Per-lane destination register |
| free_vld | input | NUM_DST | Per-lane free strobe |
| free_skip | input | NUM_DST | Per-lane: the free returns no physical entry |
| free_reg | input | NUM_DST*REG_W | Per-lane register being released |
| qry_vld | input | NUM_DST | Per-lane query valid |
| qry_reg | input | NUM_DST*REG_W | Per-lane candidate destination |
| qry_stall | output | NUM_POOLS | Per-pool overflow bit for the query group |
| used_cnt | output | NUM_POOLS*CNT_W | Used count of each pool, pool p at bits p*CNT_W |
| err_fatal | output | 1 | Sticky: one query exceeded a pool's whole capacity |
| err_underflow | output | 1 | Sticky: a release took a count below zero |

## Verification
The bench builds the block with CNT_W = 6 and POOL0_CAP = 12 and keeps the default four pools, two lanes and sixteen classes. With a global capacity of 12, a few allocations of cost-2 and cost-3 classes are enough to fill pool 0. Pool 1 is set to 4 and pool 3 to 6 and later 5, so a single two-lane query can exceed a whole pool and raise the fatal flag. Pool 2 is left at capacity 0 to cover the unbounded case next to bounded pools that are full.

// File: rtl/rct_pkg.sv
package rct_pkg;
  // Cost each class carries out of reset.
  localparam int unsigned RCT_DEF_COST = 1;
  // Pool that absorbs every charge.
  localparam int unsigned RCT_GLOBAL_POOL = 0;
endpackage

// File: rtl/rct_class_map.sv
module rct_class_map
  import rct_pkg::*;
#(
  parameter int unsigned NUM_ARCH = 16,
  parameter int unsigned PIDX_W   = 2,
  parameter int unsigned COST_W   = 3,
  parameter int unsigned REG_W    = 4,
  parameter int unsigned NUM_RD   = 6
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [REG_W-1:0]           wr_reg,
  input  logic [PIDX_W-1:0]          wr_pool,
  input  logic [COST_W-1:0]          wr_cost,
  input  logic [NUM_RD*REG_W-1:0]    rd_reg,
  output logic [NUM_RD*PIDX_W-1:0]   rd_pool,
  output logic [NUM_RD*COST_W-1:0]   rd_cost
);
  logic [PIDX_W-1:0] pool_q [NUM_ARCH];
  logic [COST_W-1:0] cost_q [NUM_ARCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_ARCH); i++) begin
        pool_q[i] <= PIDX_W'(RCT_GLOBAL_POOL);
        cost_q[i] <= COST_W'(RCT_DEF_COST);
      end
    end else if (wr_en && (32'(wr_reg) < NUM_ARCH)) begin
      pool_q[wr_reg] <= wr_pool;
      cost_q[wr_reg] <= wr_cost;
    end
  end

  for (genvar r = 0; r < int'(NUM_RD); r++) begin : g_rd
    assign rd_pool[r*PIDX_W +: PIDX_W] = pool_q[rd_reg[r*REG_W +: REG_W]];
    assign rd_cost[r*COST_W +: COST_W] = cost_q[rd_reg[r*REG_W +: REG_W]];
  end
endmodule

// File: rtl/rct_demand.sv
module rct_demand #(
  parameter int unsigned NUM_POOLS = 4,
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned PIDX_W    = 2,
  parameter int unsigned COST_W    = 3,
  parameter int unsigned SUM_W     = 8
)(
  input  logic [NUM_LANES-1:0]        lane_on,
  input  logic [NUM_LANES*PIDX_W-1:0] lane_pool,
  input  logic [NUM_LANES*COST_W-1:0] lane_cost,
  output logic [NUM_POOLS*SUM_W-1:0]  sum
);
  logic [SUM_W-1:0] cost_ext;

  always_comb begin
    sum      = '0;
    cost_ext = '0;
    for (int l = 0; l < int'(NUM_LANES); l++) begin
      if (lane_on[l]) begin
        cost_ext = SUM_W'(lane_cost[l*COST_W +: COST_W]);
        // Global pool always pays.
        sum[0 +: SUM_W] = sum[0 +: SUM_W] + cost_ext;
        for (int p = 1; p < int'(NUM_POOLS); p++) begin
          if (lane_pool[l*PIDX_W +: PIDX_W] == PIDX_W'(p))
            sum[p*SUM_W +: SUM_W] = sum[p*SUM_W +: SUM_W] + cost_ext;
        end
      end
    end
  end
endmodule

// File: rtl/rct_pool_ctr.sv
module rct_pool_ctr #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned SUM_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] add,
  input  logic [SUM_W-1:0] sub,
  output logic [CNT_W-1:0] used,
  output logic             underflow
);
  localparam int unsigned TW = SUM_W + 1;

  logic [TW-1:0] gross;

  assign gross     = TW'(used) + TW'(add);
  assign underflow = gross < TW'(sub);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         used <= '0;
    else if (underflow) used <= '0;
    else                used <= CNT_W'(gross - TW'(sub));
  end
endmodule

// File: rtl/rename_credit_tracker.sv
module rename_credit_tracker
  import rct_pkg::*;
#(
  parameter int unsigned NUM_POOLS = 4,
  parameter int unsigned NUM_DST   = 2,
  parameter int unsigned NUM_ARCH  = 16,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned COST_W    = 3,
  parameter int unsigned POOL0_CAP = 64,
  localparam int unsigned PIDX_W   = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
  localparam int unsigned REG_W    = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_map_we,
  input  logic [REG_W-1:0]             cfg_map_reg,
  input  logic [PIDX_W-1:0]            cfg_map_pool,
  input  logic [COST_W-1:0]            cfg_map_cost,
  input  logic                         cfg_cap_we,
  input  logic [PIDX_W-1:0]            cfg_cap_pool,
  input  logic [CNT_W-1:0]             cfg_cap_val,
  input  logic [NUM_DST-1:0]           alloc_vld,
  input  logic [NUM_DST-1:0]           alloc_skip,
  input  logic [NUM_DST*REG_W-1:0]     alloc_reg,
  input  logic [NUM_DST-1:0]           free_vld,
  input  logic [NUM_DST-1:0]           free_skip,
  input  logic [NUM_DST*REG_W-1:0]     free_reg,
  input  logic [NUM_DST-1:0]           qry_vld,
  input  logic [NUM_DST*REG_W-1:0]     qry_reg,
  output logic [NUM_POOLS-1:0]         qry_stall,
  output logic [NUM_POOLS*CNT_W-1:0]   used_cnt,
  output logic                         err_fatal,
  output logic                         err_underflow
);
  localparam int unsigned NUM_RD = 3 * NUM_DST;
  localparam int unsigned SUM_W  = CNT_W + $clog2(NUM_DST + 1) + 1;
  localparam int unsigned LP     = NUM_DST * PIDX_W;
  localparam int unsigned LC     = NUM_DST * COST_W;

  // Class lookup for all lanes: alloc, then free, then query.
  logic [NUM_RD*REG_W-1:0]  rd_reg;
  logic [NUM_RD*PIDX_W-1:0] rd_pool;
  logic [NUM_RD*COST_W-1:0] rd_cost;

  assign rd_reg = {qry_reg, free_reg, alloc_reg};

  rct_class_map #(
    .NUM_ARCH(NUM_ARCH), .PIDX_W(PIDX_W), .COST_W(COST_W),
    .REG_W(REG_W), .NUM_RD(NUM_RD)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_map_we),
    .wr_reg  (cfg_map_reg),
    .wr_pool (cfg_map_pool),
    .wr_cost (cfg_map_cost),
    .rd_reg  (rd_reg),
    .rd_pool (rd_pool),
    .rd_cost (rd_cost)
  );

  // Per-pool demand of each lane group.
  logic [NUM_POOLS*SUM_W-1:0] add_flat;
  logic [NUM_POOLS*SUM_W-1:0] sub_flat;
  logic [NUM_POOLS*SUM_W-1:0] qsum_flat;
  logic [NUM_DST-1:0]         alloc_on;
  logic [NUM_DST-1:0]         free_on;

  assign alloc_on = alloc_vld & ~alloc_skip;
  assign free_on  = free_vld & ~free_skip;

  rct_demand #(
    .NUM_POOLS(NUM_POOLS), .NUM_LANES(NUM_DST), .PIDX_W(PIDX_W),
    .COST_W(COST_W), .SUM_W(SUM_W)
  ) u_dem_alloc (
    .lane_on   (alloc_on),
    .lane_pool (rd_pool[0 +: LP]),
    .lane_cost (rd_cost[0 +: LC]),
    .sum       (add_flat)
  );

  rct_demand #(
    .NUM_POOLS(NUM_POOLS), .NUM_LANES(NUM_DST), .PIDX_W(PIDX_W),
    .COST_W(COST_W), .SUM_W(SUM_W)
  ) u_dem_free (
    .lane_on   (free_on),
    .lane_pool (rd_pool[LP +: LP]),
    .lane_cost (rd_cost[LC +: LC]),
    .sum       (sub_flat)
  );

  rct_demand #(
    .NUM_POOLS(NUM_POOLS), .NUM_LANES(NUM_DST), .PIDX_W(PIDX_W),
    .COST_W(COST_W), .SUM_W(SUM_W)
  ) u_dem_qry (
    .lane_on   (qry_vld),
    .lane_pool (rd_pool[2*LP +: LP]),
    .lane_cost (rd_cost[2*LC +: LC]),
    .sum       (qsum_flat)
  );

  // Pool capacities; zero means no limit.
  logic [CNT_W-1:0]           cap_q [NUM_POOLS];
  logic [NUM_POOLS*CNT_W-1:0] cap_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < int'(NUM_POOLS); p++)
        cap_q[p] <= (p == int'(RCT_GLOBAL_POOL)) ? CNT_W'(POOL0_CAP) : '0;
    end else if (cfg_cap_we) begin
      for (int p = 0; p < int'(NUM_POOLS); p++)
        if (cfg_cap_pool == PIDX_W'(p)) cap_q[p] <= cfg_cap_val;
    end
  end

  logic [NUM_POOLS-1:0] unf_hit;
  logic [NUM_POOLS-1:0] too_big;

  for (genvar p = 0; p < int'(NUM_POOLS); p++) begin : g_pool
    logic [SUM_W-1:0] req;
    logic [SUM_W:0]   need;
    logic             bounded;
    logic             asked;

    assign cap_flat[p*CNT_W +: CNT_W] = cap_q[p];

    rct_pool_ctr #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .add       (add_flat[p*SUM_W +: SUM_W]),
      .sub       (sub_flat[p*SUM_W +: SUM_W]),
      .used      (used_cnt[p*CNT_W +: CNT_W]),
      .underflow (unf_hit[p])
    );

    assign req     = qsum_flat[p*SUM_W +: SUM_W];
    assign need    = (SUM_W+1)'(used_cnt[p*CNT_W +: CNT_W]) + (SUM_W+1)'(req);
    assign bounded = (cap_q[p] != '0);
    assign asked   = (req != '0);

    assign qry_stall[p] = asked && bounded && ((SUM_W+1)'(cap_q[p]) < need);
    assign too_big[p]   = asked && bounded && (SUM_W'(cap_q[p]) < req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_fatal     <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      if (|too_big) err_fatal     <= 1'b1;
      if (|unf_hit) err_underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
  parameter int unsigned NUM_POOLS = 4,
  parameter int unsigned NUM_DST   = 2,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SUM_W     = 10
)(
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_DST-1:0]         alloc_vld,
  input logic [NUM_DST-1:0]         alloc_skip,
  input logic [NUM_DST-1:0]         free_vld,
  input logic [NUM_DST-1:0]         free_skip,
  input logic [NUM_POOLS-1:0]       qry_stall,
  input logic [NUM_POOLS*CNT_W-1:0] used_cnt,
  input logic [NUM_POOLS*CNT_W-1:0] cap_flat,
  input logic [NUM_POOLS*SUM_W-1:0] qsum_flat,
  input logic                       err_fatal,
  input logic                       err_underflow
);
  // R9: fatal flag never drops outside reset.
  p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |=> err_fatal);

  // R10: underflow flag never drops outside reset.
  p_underflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

  // R4: with no charging lane in either group, no count moves.
  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(alloc_vld & ~alloc_skip)) && !(|(free_vld & ~free_skip)))
    |=> $stable(used_cnt));

  for (genvar p = 0; p < int'(NUM_POOLS); p++) begin : g_pool
    // R7: unlimited pool never stalls.
    p_unbounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flat[p*CNT_W +: CNT_W] == '0) |-> !qry_stall[p]);

    // R8: untouched pool never stalls.
    p_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (qsum_flat[p*SUM_W +: SUM_W] == '0) |-> !qry_stall[p]);
  end
endmodule

bind rename_credit_tracker rct_checker #(
  .NUM_POOLS(NUM_POOLS), .NUM_DST(NUM_DST), .CNT_W(CNT_W), .SUM_W(SUM_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_vld     (alloc_vld),
  .alloc_skip    (alloc_skip),
  .free_vld      (free_vld),
  .free_skip     (free_skip),
  .qry_stall     (qry_stall),
  .used_cnt      (used_cnt),
  .cap_flat      (cap_flat),
  .qsum_flat     (qsum_flat),
  .err_fatal     (err_fatal),
  .err_underflow (err_underflow)
);

// File: tb/tb_rename_credit_tracker.sv
`timescale 1ns/1ps
module tb_rename_credit_tracker;
  localparam int NP = 4;
  localparam int ND = 2;
  localparam int NA = 16;
  localparam int CW = 6;
  localparam int COW = 3;
  localparam int P0CAP = 12;
  localparam int PW = 2;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic            cfg_map_we;
  logic [RW-1:0]   cfg_map_reg;
  logic [PW-1:0]   cfg_map_pool;
  logic [COW-1:0]  cfg_map_cost;
  logic            cfg_cap_we;
  logic [PW-1:0]   cfg_cap_pool;
  logic [CW-1:0]   cfg_cap_val;
  logic [ND-1:0]   alloc_vld, alloc_skip, free_vld, free_skip, qry_vld;
  logic [ND*RW-1:0] alloc_reg, free_reg, qry_reg;
  logic [NP-1:0]   qry_stall;
  logic [NP*CW-1:0] used_cnt;
  logic            err_fatal, err_underflow;

  rename_credit_tracker #(
    .NUM_POOLS(NP), .NUM_DST(ND), .NUM_ARCH(NA), .CNT_W(CW),
    .COST_W(COW), .POOL0_CAP(P0CAP)
  ) dut (.*);

  // Independent model of the requirements.
  int m_pool [NA];
  int m_cost [NA];
  int m_cap  [NP];
  int m_used [NP];
  bit m_fatal, m_unf;

  // Scoreboard queues.
  logic [NP*CW-1:0] q_used [$];
  logic [NP-1:0]    q_stall [$];
  bit               q_fat [$];
  bit               q_unf [$];
  string            q_tag [$];

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic idle_inputs();
    cfg_map_we = 0; cfg_map_reg = '0; cfg_map_pool = '0; cfg_map_cost = '0;
    cfg_cap_we = 0; cfg_cap_pool = '0; cfg_cap_val = '0;
    alloc_vld = '0; alloc_skip = '0; alloc_reg = '0;
    free_vld = '0; free_skip = '0; free_reg = '0;
    qry_vld = '0; qry_reg = '0;
  endtask

  task automatic do_alloc(input int lane, input int r, input bit skip);
    alloc_vld[lane] = 1'b1; alloc_skip[lane] = skip;
    alloc_reg[lane*RW +: RW] = RW'(r);
  endtask

  task automatic do_free(input int lane, input int r, input bit skip);
    free_vld[lane] = 1'b1; free_skip[lane] = skip;
    free_reg[lane*RW +: RW] = RW'(r);
  endtask

  task automatic do_qry(input int lane, input int r);
    qry_vld[lane] = 1'b1;
    qry_reg[lane*RW +: RW] = RW'(r);
  endtask

  task automatic do_map(input int r, input int p, input int c);
    cfg_map_we = 1'b1; cfg_map_reg = RW'(r);
    cfg_map_pool = PW'(p); cfg_map_cost = COW'(c);
  endtask

  task automatic do_cap(input int p, input int v);
    cfg_cap_we = 1'b1; cfg_cap_pool = PW'(p); cfg_cap_val = CW'(v);
  endtask

  // Driver: push the expectation for this cycle, advance the model, move on.
  task automatic cycle(input string tag);
    int req [NP];
    int add [NP];
    int sub [NP];
    int r, t;
    bit fat;
    logic [NP*CW-1:0] ue;
    logic [NP-1:0] se;
    fat = 0;
    for (int p = 0; p < NP; p++) begin req[p] = 0; add[p] = 0; sub[p] = 0; end
    for (int l = 0; l < ND; l++) begin
      if (qry_vld[l]) begin
        r = int'(qry_reg[l*RW +: RW]);
        req[0] += m_cost[r];
        if (m_pool[r] != 0) req[m_pool[r]] += m_cost[r];
      end
      if (alloc_vld[l] && !alloc_skip[l]) begin
        r = int'(alloc_reg[l*RW +: RW]);
        add[0] += m_cost[r];
        if (m_pool[r] != 0) add[m_pool[r]] += m_cost[r];
      end
      if (free_vld[l] && !free_skip[l]) begin
        r = int'(free_reg[l*RW +: RW]);
        sub[0] += m_cost[r];
        if (m_pool[r] != 0) sub[m_pool[r]] += m_cost[r];
      end
    end
    for (int p = 0; p < NP; p++) begin
      ue[p*CW +: CW] = CW'(m_used[p]);
      se[p] = (req[p] != 0) && (m_cap[p] != 0) && (m_cap[p] < m_used[p] + req[p]);
      if ((req[p] != 0) && (m_cap[p] != 0) && (m_cap[p] < req[p])) fat = 1;
    end
    q_used.push_back(ue); q_stall.push_back(se);
    q_fat.push_back(m_fatal); q_unf.push_back(m_unf); q_tag.push_back(tag);
    // Model state after the coming edge.
    for (int p = 0; p < NP; p++) begin
      t = m_used[p] + add[p];
      if (t < sub[p]) begin m_used[p] = 0; m_unf = 1; end
      else m_used[p] = (t - sub[p]) % (1 << CW);
    end
    if (fat) m_fatal = 1;
    if (cfg_map_we) begin
      m_pool[int'(cfg_map_reg)] = int'(cfg_map_pool);
      m_cost[int'(cfg_map_reg)] = int'(cfg_map_cost);
    end
    if (cfg_cap_we) m_cap[int'(cfg_cap_pool)] = int'(cfg_cap_val);
    @(posedge clk); #1;
    idle_inputs();
  endtask

  // Monitor: compare at the falling edge.
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      logic [NP*CW-1:0] eu;
      logic [NP-1:0] es;
      bit ef, en;
      string tg;
      eu = q_used.pop_front(); es = q_stall.pop_front();
      ef = q_fat.pop_front(); en = q_unf.pop_front(); tg = q_tag.pop_front();
      n_chk++;
      if (used_cnt !== eu || qry_stall !== es || err_fatal !== ef || err_underflow !== en) begin
        n_err++;
        $display("FAIL %s: used=%h exp %h stall=%b exp %b fatal=%b exp %b underflow=%b exp %b",
                 tg, used_cnt, eu, qry_stall, es, err_fatal, ef, err_underflow, en);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    idle_inputs();
    for (int i = 0; i < NA; i++) begin m_pool[i] = 0; m_cost[i] = 1; end
    for (int p = 0; p < NP; p++) begin m_cap[p] = (p == 0) ? P0CAP : 0; m_used[p] = 0; end
    m_fatal = 0; m_unf = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cycle("R1");                                        // reset state
    do_alloc(0, 0, 0); do_alloc(1, 9, 0); cycle("R2");  // default class, pool 0 once
    do_map(3, 1, 2); do_qry(0, 3); cycle("R11");        // query sees old class
    do_map(5, 2, 1); do_qry(0, 3); cycle("R11");        // new class now visible
    do_map(7, 3, 3); cycle("R11");
    do_cap(1, 4); cycle("R11");
    do_cap(3, 6); cycle("R11");
    do_alloc(0, 3, 0); do_qry(0, 3); cycle("R2");
    do_alloc(0, 3, 0); do_alloc(1, 5, 0); cycle("R12"); // lanes summed
    do_qry(0, 3); cycle("R6");                          // pool 1 stalls
    do_qry(0, 5); do_qry(1, 5); cycle("R7");            // unbounded pool 2
    do_qry(0, 7); cycle("R8");                          // full pool 1 untouched
    do_alloc(0, 3, 1); do_free(1, 5, 1); cycle("R4");   // skipped lanes
    cycle("R4");
    do_alloc(0, 7, 0); do_free(0, 3, 0); cycle("R5");   // both applied
    cycle("R5");
    do_free(0, 5, 0); cycle("R3");
    cycle("R3");
    do_qry(0, 7); do_qry(1, 7); cycle("R6");            // pools 0 and 3 stall
    do_cap(3, 5); cycle("R9");
    do_qry(0, 7); do_qry(1, 7); cycle("R9");            // exceeds whole pool 3
    cycle("R9");
    cycle("R9");
    do_free(0, 5, 0); cycle("R10");                     // pool 2 below zero
    cycle("R10");
    do_alloc(0, 0, 0); do_qry(1, 0); cycle("R2");
    cycle("R2");
    @(negedge clk); #1;
    if (q_tag.size() != 0) begin
      n_err++; n_chk++;
      $display("FAIL drain: pending=%0d expected=0", q_tag.size());
    end
    finish_run();
  end
endmodule